// File: doc/BRIEF.md
# UART Bit-Rate Tick Selector

This block produces the bit-rate enable pulse for a serial port. It runs on the core clock and chooses among three sources according to a two-bit serial mode, a double-rate input and a stored source-select bit. The two synchronous and fixed-rate modes use fixed divide ratios. The two variable-rate modes use one of two paths. The first is an 8-bit reload timer whose count is scaled by 64, or by 32 at double rate. The second is an independent 16-bit divisor with a fixed offset of 16.

Software programs the block through a byte-wide write port that has four addresses: the divisor low byte, the divisor high byte, a small control register and the timer reload byte. The divisor bytes can be changed only while the independent generator is disabled, so a half-written divisor is never used. Any change of mode, double-rate or source select restarts the divide chain, so the port never sees a shortened tick period.

Top module: `baud_select_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `baud_tick` is 0. Reset clears the divisor, the reload byte, the enable bit and the source-select bit.
- R2: With `mode` = 0, a tick occurs every 16 core cycles. `dbl_rate` and the source-select bit have no effect.
- R3: With `mode` = 2, a tick occurs every 32 cycles when `dbl_rate` is 0 and every 16 cycles when it is 1. The source-select bit has no effect.
- R4: With `mode` = 1 or 3 and source select 0, the period is (256 − reload) × 64 cycles when `dbl_rate` is 0 and (256 − reload) × 32 cycles when it is 1.
- R5: With `mode` = 1 or 3, source select 1 and the enable set, the period is {high,low} + 16 cycles, and `dbl_rate` has no effect.
- R6: With `mode` = 1 or 3, source select 1 and the enable clear, no tick is produced.
- R7: A write to either divisor byte while the enable is 1 is ignored. The active divisor, and therefore the period, is unchanged.
- R8: A change of `mode`, `dbl_rate` or source select suppresses any tick in the cycle of the change and restarts the count. The first tick after the change comes P+1 cycles later, where P is the new period.
- R9: Each tick is high for exactly one cycle. In steady state, successive ticks are exactly P cycles apart.
- R10: Write address 0 loads the divisor low byte and address 1 loads the high byte. Address 2 loads the control register: data bit 0 is the enable and data bit 1 is source select, and data bits 7..2 are ignored. Address 3 loads the reload byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 low, 1 high, 2 control, 3 reload) |
| wr_data | input | 8 | Write data |
| mode | input | 2 | Serial mode (0..3) |
| dbl_rate | input | 1 | Double-rate select |
| baud_tick | output | 1 | One-cycle bit-rate enable |

## Verification
Four properties are checked on every cycle. They cover the single-cycle width of the tick, silence while the divisor path is selected but disabled, the lock on divisor bytes while the enable is set, and the decode of the enable and select bits from a control write. The divide ratio of each mode, the P+1 latency after a restart and the exact steady-state spacing can only be shown by the bench scenarios. In those scenarios a behavioural model is compared with the tick on every clock, and the period between ticks is measured directly.

// File: rtl/baud_select_gen.sv
module baud_select_gen #(
  parameter int FAST_DIV   = 16,
  parameter int SLOW_DIV   = 32,
  parameter int DIV_OFFSET = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] mode,
  input  logic       dbl_rate,
  output logic       baud_tick
);
  localparam int DIV_W = 16;
  localparam int RLD_W = 8;
  localparam int CW    = DIV_W + 2;

  logic [DIV_W-1:0] div_q;
  logic [RLD_W-1:0] rld_q;
  logic             gen_en, src_sel;
  logic [CW-1:0]    cnt, period;
  logic [3:0]       cfg_now, cfg_q;
  logic             running, restart, term;
  logic [RLD_W:0]   rld_span;

  assign rld_span = (RLD_W+1)'(2**RLD_W) - {1'b0, rld_q};

  always_comb begin
    if (!mode[0])
      period = (mode[1] && !dbl_rate) ? CW'(SLOW_DIV) : CW'(FAST_DIV);
    else if (src_sel)
      period = CW'(div_q) + CW'(DIV_OFFSET);
    else
      period = CW'(rld_span) << (dbl_rate ? 5 : 6);
  end

  assign cfg_now   = {mode, dbl_rate, src_sel};
  assign running   = !(mode[0] && src_sel && !gen_en);
  assign restart   = cfg_now != cfg_q;
  assign term      = cnt >= period - CW'(1);
  assign baud_tick = running && !restart && term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      rld_q   <= '0;
      gen_en  <= 1'b0;
      src_sel <= 1'b0;
      cnt     <= '0;
      cfg_q   <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (!running || restart || term) cnt <= '0;
      else                             cnt <= cnt + CW'(1);
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (!gen_en) div_q[7:0]  <= wr_data;
          2'd1: if (!gen_en) div_q[15:8] <= wr_data;
          2'd2: {src_sel, gen_en} <= wr_data[1:0];
          default: rld_q <= wr_data;
        endcase
      end
    end
  end

  // R9
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && src_sel && !gen_en) |-> !baud_tick);

  // R7
  div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && wr_en && !wr_addr[1]) |=> $stable(div_q));

  // R10
  ctrl_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=>
      (gen_en == $past(wr_data[0]) && src_sel == $past(wr_data[1])));
endmodule

// File: tb/baud_select_gen_test.sv
module baud_select_gen_test;
  logic       clk = 0, rst_n = 0, wr_en = 0, dbl_rate = 0;
  logic [1:0] wr_addr = 0, mode = 0;
  logic [7:0] wr_data = 0;
  logic       baud_tick;

  int checks = 0, errors = 0, cycles = 0;
  string cur = "R1";
  int m_lo, m_hi, m_rel, m_cnt, m_cfg;
  bit m_en, m_sel;

  baud_select_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode), .dbl_rate(dbl_rate), .baud_tick(baud_tick));

  always #5 clk = ~clk;

  function automatic int mperiod();
    if (mode[0] == 1'b0) return (mode == 2'd2 && !dbl_rate) ? 32 : 16;
    if (m_sel) return m_hi * 256 + m_lo + 16;
    return (256 - m_rel) * (dbl_rate ? 32 : 64);
  endfunction

  function automatic int cfg_code();
    return {28'd0, mode, dbl_rate, m_sel};
  endfunction

  function automatic bit m_run();
    return !(mode[0] && m_sel && !m_en);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_rel = 0; m_en = 0; m_sel = 0; m_cnt = 0; m_cfg = 0;
    end else begin
      automatic int p = mperiod();
      automatic bit rs = cfg_code() != m_cfg;
      if (!m_run() || rs || m_cnt >= p - 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_cfg = cfg_code();
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (!m_en) m_lo = int'(wr_data);
          2'd1: if (!m_en) m_hi = int'(wr_data);
          2'd2: begin m_en = wr_data[0]; m_sel = wr_data[1]; end
          default: m_rel = int'(wr_data);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    automatic bit exp_t = 0;
    if (rst_n) exp_t = m_run() && (cfg_code() == m_cfg) && (m_cnt >= mperiod() - 1);
    checks++;
    if (baud_tick !== exp_t) begin
      errors++;
      $display("FAIL %s cycle tick actual=%0b expected=%0b", cur, baud_tick, exp_t);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic setcfg(input logic [1:0] m, input logic d);
    @(posedge clk); #1 mode = m; dbl_rate = d;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic measure(input int exp_p, input string req);
    int n = 0;
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!baud_tick && guard < 40000);
    do begin @(negedge clk); n++; end while (!baud_tick && n < 40000);
    check(n == exp_p, req, n, exp_p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(baud_tick == 1'b0, "R1", baud_tick, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(baud_tick == 1'b0, "R1", baud_tick, 0);

    cur = "R2";
    wr(2, 8'h03);
    setcfg(0, 1);
    measure(16, "R2");
    setcfg(0, 0);
    measure(16, "R2");

    cur = "R3";
    setcfg(2, 0);
    measure(32, "R3");
    setcfg(2, 1);
    measure(16, "R3");

    cur = "R8";
    do @(negedge clk); while (!baud_tick);
    repeat (3) @(negedge clk);
    begin
      int n = 0;
      setcfg(2, 0);
      do begin @(negedge clk); n++; end while (!baud_tick && n < 1000);
      check(n == 33, "R8", n, 33);
    end
    measure(32, "R9");

    cur = "R4";
    wr(2, 8'h00);
    wr(3, 8'd254);
    setcfg(1, 0);
    measure(128, "R4");
    setcfg(1, 1);
    measure(64, "R4");
    wr(3, 8'd255);
    setcfg(3, 1);
    measure(32, "R4");

    cur = "R6";
    setcfg(1, 0);
    wr(2, 8'h02);
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (baud_tick) seen++; end
      check(seen == 0, "R6", seen, 0);
    end
    wr(0, 8'd4);
    wr(1, 8'd0);

    cur = "R5";
    wr(2, 8'h03);
    measure(20, "R5");
    setcfg(1, 1);
    measure(20, "R5");
    setcfg(3, 0);
    measure(20, "R5");

    cur = "R7";
    wr(0, 8'd100);
    wr(1, 8'd1);
    measure(20, "R7");

    cur = "R10";
    wr(2, 8'hFD);
    setcfg(3, 1);
    measure(32, "R10");
    wr(2, 8'h02);
    wr(1, 8'd1);
    wr(0, 8'd0);
    wr(2, 8'hFF);
    measure(272, "R10");
    wr(2, 8'h02);
    wr(1, 8'd0);
    wr(0, 8'd9);
    wr(2, 8'h03);
    measure(25, "R9");

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule